// File: doc/BRIEF.md
# Program Address Sequencer with One-Level Return Stack

This block produces the program address for a small microcontroller core. Each cycle in which the core finishes an instruction (the `step` strobe), the sequencer picks the next address. It either advances by the instruction length (1 or 2 bytes), or loads a jump target when the decoded condition holds. It also handles one level of subroutine call and return. Program-counter arithmetic wraps modulo 1024.

The return address lives in a single 10-bit link register. A state machine with three states tracks the stack pointer:
- **ST_EMPTY**: no call is outstanding. A CALL moves to ST_FULL. A RET moves to ST_TRAP.
- **ST_FULL**: one call is outstanding. A RET moves to ST_EMPTY. A second CALL moves to ST_TRAP.
- **ST_TRAP**: the one-cycle recovery state, entered on stack overflow or underflow. It always returns to ST_EMPTY on the next clock.

No-step cycles and other opcodes keep the state. In ST_TRAP the reset request output is high, the program address is zero and any step is ignored.

The low 8 bits of the link register also appear as a data-memory location, through a read port and a write strobe. A data write clears the two upper bits. The link register has no reset, so its contents survive both a return and a reset.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc` is 0 and `sys_rst_req` is 0. The stack is empty, so a RET as the first step faults.
- R2: On a step with `op`=0 (sequential), `pc` becomes `pc` + 1 when `ilen`=0, or `pc` + 2 when `ilen`=1, modulo 1024. This is visible after the clock edge of the step.
- R3: On a step, `op` selects a jump. `op`=1 always loads `target`. `op`=2 loads `target` if `carry`=1. `op`=3 loads it if `carry`=0. `op`=4 loads it if `flag`=1. `op`=5 loads it if `flag`=0. A jump whose condition fails advances as in R2.
- R4: A step with `op`=6 (CALL) in ST_EMPTY does three things: it saves `pc` + length into the link register, loads `target` into `pc`, and enters ST_FULL.
- R5: A step with `op`=7 (RET) in ST_FULL loads the link register into `pc` and enters ST_EMPTY. The link register is left unchanged.
- R6: A CALL in ST_FULL (overflow) or a RET in ST_EMPTY (underflow) sets `pc` to 0 and enters ST_TRAP. It raises `sys_rst_req` for exactly one cycle and leaves the link register unchanged.
- R7: In ST_TRAP any step is ignored: `pc` stays 0 and the next state is ST_EMPTY.
- R8: The link register keeps its value across `rst_n` being asserted.
- R9: `dm_rdata` always shows link bits 7..0. A `dm_wr` without a concurrent CALL save writes `dm_wdata` into those bits and clears bits 9..8. A CALL save in the same cycle takes precedence over `dm_wr`.
- R10: With `step` low and no trap in progress, `pc` and the stack state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | An instruction completes this cycle |
| op | input | 3 | Control-transfer code (0 seq, 1 jmp, 2 jc, 3 jnc, 4 jf, 5 jnf, 6 call, 7 ret) |
| target | input | 10 | Jump or call destination |
| ilen | input | 1 | Instruction length: 0 = 1 byte, 1 = 2 bytes |
| carry | input | 1 | Carry condition bit |
| flag | input | 1 | General flag condition bit |
| dm_wr | input | 1 | Data-memory write to the link register low byte |
| dm_wdata | input | 8 | Data written by `dm_wr` |
| dm_rdata | output | 8 | Link register bits 7..0 |
| pc | output | 10 | Program address |
| sys_rst_req | output | 1 | One-cycle reset request on stack overflow or underflow |

## Verification
Every result in this block comes from a register loaded at the clock edge that captures the stimulus. The bench therefore drives inputs just after a falling edge and compares `pc`, `sys_rst_req` and `dm_rdata` at the next falling edge, one cycle later. The reset request is checked high exactly at that sample after a faulting step and low at the sample after that. This is also the sample at which a step issued during the trap shows `pc` still 0. The bench sweeps every opcode against every combination of carry, flag and length, with a reference model that walks through the stack states. It then covers wrap-around, faults during the trap, data writes and retention across reset.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JMP  = 3'd1,
        OP_JC   = 3'd2,
        OP_JNC  = 3'd3,
        OP_JF   = 3'd4,
        OP_JNF  = 3'd5,
        OP_CALL = 3'd6,
        OP_RET  = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FULL  = 2'd1,
        ST_TRAP  = 2'd2
    } stk_state_e;

    // Jump condition evaluation; non-jump codes report not taken.
    function automatic logic jump_taken(input seq_op_e o, input logic c, input logic f);
        logic t;
        unique case (o)
            OP_JMP:  t = 1'b1;
            OP_JC:   t = c;
            OP_JNC:  t = ~c;
            OP_JF:   t = f;
            OP_JNF:  t = ~f;
            default: t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/seq_stack_fsm.sv
module seq_stack_fsm
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       is_call,
    input  logic       is_ret,
    output stk_state_e state,
    output logic       step_ok,
    output logic       fault,
    output logic       stack_full,
    output logic       rst_req
);

    stk_state_e state_q, state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (step && is_call)     state_d = ST_FULL;
                else if (step && is_ret) state_d = ST_TRAP;
            end
            ST_FULL: begin
                if (step && is_call)     state_d = ST_TRAP;
                else if (step && is_ret) state_d = ST_EMPTY;
            end
            ST_TRAP:  state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        state      = state_q;
        stack_full = (state_q == ST_FULL);
        rst_req    = (state_q == ST_TRAP);
        step_ok    = step && (state_q != ST_TRAP);
        fault      = step && (((state_q == ST_FULL)  && is_call) ||
                              ((state_q == ST_EMPTY) && is_ret));
    end

    // R6: reset request lasts a single cycle
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: a fault always lands in the trap state
    p_fault_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> rst_req);

    // R7: the trap state always leaves to the empty state
    p_trap_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP) |=> (state_q == ST_EMPTY));

    // R10: no step and no trap keeps the stack state
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && state_q != ST_TRAP) |=> $stable(state_q));

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_ok,
    input  logic            fault,
    input  seq_op_e         op,
    input  logic [PC_W-1:0] target,
    input  logic            ilen,
    input  logic            carry,
    input  logic            flag,
    input  logic [PC_W-1:0] ret_addr,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] link
);

    localparam int LEN_PAD = PC_W - 2;

    logic [PC_W-1:0] pc_q, pc_d;
    logic [1:0]      len_bytes;

    always_comb begin
        len_bytes = ilen ? 2'd2 : 2'd1;
        link      = pc_q + {{LEN_PAD{1'b0}}, len_bytes};
    end

    always_comb begin
        pc_d = pc_q;
        if (fault) begin
            pc_d = '0;
        end else if (step_ok) begin
            unique case (op)
                OP_SEQ:  pc_d = link;
                OP_JMP, OP_JC, OP_JNC, OP_JF, OP_JNF:
                         pc_d = jump_taken(op, carry, flag) ? target : link;
                OP_CALL: pc_d = target;
                OP_RET:  pc_d = ret_addr;
                default: pc_d = link;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    // R2: a sequential step advances by the length
    p_seq_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && !fault && op == OP_SEQ) |=>
        (pc_q == $past(pc_q) + (($past(ilen)) ? PC_W'(2) : PC_W'(1))));

    // R3: unconditional jump lands on its target
    p_jmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && op == OP_JMP) |=> (pc_q == $past(target)));

    // R6: a fault sends the address to zero
    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (pc_q == '0));

    // R10: no accepted step holds the address
    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_ok && !fault) |=> $stable(pc_q));

endmodule

// File: rtl/seq_ret_reg.sv
module seq_ret_reg #(
    parameter int PC_W   = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save,
    input  logic [PC_W-1:0]   link,
    input  logic              dm_wr,
    input  logic [DATA_W-1:0] dm_wdata,
    output logic [PC_W-1:0]   ret_addr,
    output logic [DATA_W-1:0] dm_rdata
);

    localparam int HI_W = PC_W - DATA_W;

    logic [PC_W-1:0] lnk_q;

    // No reset: contents survive reset and return.
    always_ff @(posedge clk) begin
        if (save)       lnk_q <= link;
        else if (dm_wr) lnk_q <= {{HI_W{1'b0}}, dm_wdata};
    end

    assign ret_addr = lnk_q;
    assign dm_rdata = lnk_q[DATA_W-1:0];

    // R9: a data write shows up on the read port and clears the top bits
    p_dm_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_wr && !save) |=>
        (dm_rdata == $past(dm_wdata) && ret_addr[PC_W-1:DATA_W] == '0));

    // R4: a save records the link address
    p_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> (ret_addr == $past(link)));

    // R5/R6: without save or write the register is untouched
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!save && !dm_wr) |=> $stable(lnk_q));

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import seq_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [2:0]        op,
    input  logic [PC_W-1:0]   target,
    input  logic              ilen,
    input  logic              carry,
    input  logic              flag,
    input  logic              dm_wr,
    input  logic [DATA_W-1:0] dm_wdata,
    output logic [DATA_W-1:0] dm_rdata,
    output logic [PC_W-1:0]   pc,
    output logic              sys_rst_req
);

    seq_op_e         op_e;
    stk_state_e      stk_state;
    logic            is_call, is_ret;
    logic            step_ok, fault, stack_full, save;
    logic [PC_W-1:0] link, ret_addr;

    always_comb begin
        op_e    = seq_op_e'(op);
        is_call = (op_e == OP_CALL);
        is_ret  = (op_e == OP_RET);
        save    = step_ok && is_call && !stack_full;
    end

    seq_stack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .is_call    (is_call),
        .is_ret     (is_ret),
        .state      (stk_state),
        .step_ok    (step_ok),
        .fault      (fault),
        .stack_full (stack_full),
        .rst_req    (sys_rst_req)
    );

    seq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_ok  (step_ok),
        .fault    (fault),
        .op       (op_e),
        .target   (target),
        .ilen     (ilen),
        .carry    (carry),
        .flag     (flag),
        .ret_addr (ret_addr),
        .pc       (pc),
        .link     (link)
    );

    seq_ret_reg #(.PC_W(PC_W), .DATA_W(DATA_W)) u_lnk (
        .clk      (clk),
        .rst_n    (rst_n),
        .save     (save),
        .link     (link),
        .dm_wr    (dm_wr),
        .dm_wdata (dm_wdata),
        .ret_addr (ret_addr),
        .dm_rdata (dm_rdata)
    );

    // R4: call from empty jumps to target and fills the stack
    p_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && is_call && !stack_full) |=>
        (pc == $past(target) && stk_state == ST_FULL));

    // R5: return from full restores the saved address
    p_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && is_ret && stack_full) |=>
        (pc == $past(ret_addr) && stk_state == ST_EMPTY));

    // R7: a step during the trap leaves the address at zero
    p_trap_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (pc == '0));

    // R1: reset request only follows a fault
    p_req_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> $past(fault));

endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_SEQ = 3'd0, C_JMP = 3'd1, C_JC = 3'd2, C_JNC = 3'd3,
                           C_JF = 3'd4, C_JNF = 3'd5, C_CALL = 3'd6, C_RET = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [2:0] op = '0;
    logic [9:0] target = '0;
    logic       ilen = 1'b0, carry = 1'b0, flag = 1'b0;
    logic       dm_wr = 1'b0;
    logic [7:0] dm_wdata = '0;
    logic [7:0] dm_rdata;
    logic [9:0] pc;
    logic       sys_rst_req;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [9:0] m_pc = '0;
    logic       m_full = 1'b0;
    logic       m_trap = 1'b0;
    logic [9:0] m_lnk = '0;
    logic       m_lnk_ok = 1'b0;

    prog_seq dut (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op), .target(target),
        .ilen(ilen), .carry(carry), .flag(flag), .dm_wr(dm_wr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pc(pc),
        .sys_rst_req(sys_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "pc", pc, m_pc);
        chk(req, "sys_rst_req", sys_rst_req, m_trap);
        if (m_lnk_ok) chk(req, "dm_rdata", dm_rdata, m_lnk[7:0]);
    endtask

    // One clock: drive after a falling edge, compare at the next falling edge.
    task automatic cycle(input logic s, input logic [2:0] o, input logic [9:0] t,
                         input logic l, input logic c, input logic f,
                         input logic w, input logic [7:0] wd);
        string req;
        logic [9:0] nxt;
        logic flt;
        step = s; op = o; target = t; ilen = l; carry = c; flag = f;
        dm_wr = w; dm_wdata = wd;
        flt = 1'b0;
        req = "R10";
        nxt = m_pc + (l ? 10'd2 : 10'd1);
        if (m_trap) begin
            m_trap = 1'b0;
            req = "R7";
        end else if (s) begin
            case (o)
                C_SEQ: begin m_pc = nxt; req = "R2"; end
                C_JMP: begin m_pc = t; req = "R3"; end
                C_JC:  begin m_pc = c  ? t : nxt; req = "R3"; end
                C_JNC: begin m_pc = !c ? t : nxt; req = "R3"; end
                C_JF:  begin m_pc = f  ? t : nxt; req = "R3"; end
                C_JNF: begin m_pc = !f ? t : nxt; req = "R3"; end
                C_CALL: begin
                    if (m_full) flt = 1'b1;
                    else begin
                        m_lnk = nxt; m_lnk_ok = 1'b1; m_pc = t; m_full = 1'b1; req = "R4";
                        w = 1'b0;
                    end
                end
                default: begin
                    if (!m_full) flt = 1'b1;
                    else begin m_pc = m_lnk; m_full = 1'b0; req = "R5"; end
                end
            endcase
            if (flt) begin
                m_pc = '0; m_full = 1'b0; m_trap = 1'b1; req = "R6";
            end
        end
        if (w) begin
            m_lnk = {2'b00, wd}; m_lnk_ok = 1'b1;
            if (!s || o != C_CALL) req = "R9";
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
        step = 1'b0; dm_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step = 1'b0; dm_wr = 1'b0;
        m_pc = '0; m_full = 1'b0; m_trap = 1'b0;
        @(negedge clk);
        chk("R1", "pc in reset", pc, 0);
        chk("R1", "req in reset", sys_rst_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // R1: first step is a RET and must underflow
        cycle(1, C_RET, 10'h000, 0, 0, 0, 0, 8'h00);
        chk("R1", "underflow req after reset", sys_rst_req, 1);
        cycle(0, C_SEQ, 0, 0, 0, 0, 0, 0);

        // Sweep all opcodes against carry, flag and length
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 8; k++) begin
                cycle(1, 3'(o), 10'((o * 131 + k * 37 + 5) % 1024),
                      k[0], k[1], k[2], 0, 8'h00);
            end
        end
        cycle(0, C_SEQ, 0, 0, 0, 0, 0, 0);

        // R2: wrap-around at the top of the address space
        cycle(1, C_JMP, 10'h3FF, 0, 0, 0, 0, 0);
        cycle(1, C_SEQ, 0, 1, 0, 0, 0, 0);
        chk("R2", "wrap by 2", pc, 1);
        cycle(1, C_JMP, 10'h3FE, 0, 0, 0, 0, 0);
        cycle(1, C_SEQ, 0, 0, 0, 0, 0, 0);
        cycle(1, C_SEQ, 0, 0, 0, 0, 0, 0);
        chk("R2", "wrap by 1", pc, 0);

        // R4/R5: call with length 2 from the top, then return
        cycle(1, C_JMP, 10'h3FF, 0, 0, 0, 0, 0);
        cycle(1, C_CALL, 10'h155, 1, 0, 0, 0, 0);
        chk("R4", "link after call", dm_rdata, 8'h01);
        cycle(1, C_RET, 0, 0, 0, 0, 0, 0);
        chk("R5", "return target", pc, 1);
        cycle(1, C_RET, 0, 0, 0, 0, 0, 0);
        chk("R5", "link kept after return", dm_rdata, 8'h01);

        // R7: steps during the trap cycle are ignored
        cycle(1, C_JMP, 10'h222, 0, 0, 0, 0, 0);
        cycle(1, C_SEQ, 0, 0, 0, 0, 0, 0);

        // R6: overflow, with a call during the trap ignored
        cycle(1, C_CALL, 10'h100, 0, 0, 0, 0, 0);
        cycle(1, C_CALL, 10'h200, 0, 0, 0, 0, 0);
        cycle(1, C_CALL, 10'h300, 0, 0, 0, 0, 0);
        cycle(1, C_RET, 0, 0, 0, 0, 0, 0);
        cycle(0, C_SEQ, 0, 0, 0, 0, 0, 0);

        // R9: data write then return through written value
        cycle(1, C_CALL, 10'h0F0, 0, 0, 0, 0, 0);
        cycle(0, C_SEQ, 0, 0, 0, 0, 1, 8'hA5);
        chk("R9", "read back", dm_rdata, 8'hA5);
        cycle(1, C_RET, 0, 0, 0, 0, 0, 0);
        chk("R9", "upper bits cleared", pc, 10'h0A5);
        // R9: call save wins over a concurrent write
        cycle(1, C_CALL, 10'h010, 1, 0, 0, 1, 8'h3C);
        chk("R9", "call beats write", dm_rdata, 8'hA7);

        // R10: idle cycles hold pc and the full stack
        for (int i = 0; i < 4; i++) cycle(0, C_JMP, 10'h3AA, 1, 1, 1, 0, 0);
        chk("R10", "pc held", pc, 10'h010);

        // R8: link register survives reset
        do_reset();
        chk("R8", "link after reset", dm_rdata, 8'hA7);
        cycle(1, C_RET, 0, 0, 0, 0, 0, 0);
        cycle(0, C_SEQ, 0, 0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule